// File: doc/BRIEF.md
# Pipelined Histogram Count Updater

This block builds an occurrence histogram for a counting-sort engine. Every accepted sample is a key, and that key is used directly as the address of its own counter in an internal two-port RAM. Each accepted sample reads its counter, adds one and writes the result back. The read, the update and the write-back each take one register stage, so the block takes one sample on every clock and keeps the per-key arithmetic exact. When a newer sample hits a key that an older sample has not yet written back, the newer sample uses the in-flight updated count instead of the stale RAM word. As a result, long runs of one key and rapid toggling between two keys are both counted exactly. Counters saturate at all-ones.

The sample input is a valid/ready stream that is qualified by a frame flag. A sample is taken on a rising edge when `frame_valid`, `sample_valid` and `sample_ready` are all high. `sample_ready` is low while a clear sweep runs and in the cycle `clear_start` is asserted. A source that sees `sample_ready` low must hold its sample and offer it again later. Outside a frame, the RAM's read port serves a downstream reader through `rd_addr`/`rd_count`. A pulse on `clear_start` throws away whatever is in the pipeline, writes zero to every counter at one address per cycle and then pulses `clear_done`. RAM contents are undefined until the first clear.

Top module: `hist_count_updater`

## Requirements
- R1: After reset, `clear_done` is low and no clear sweep is running, so `sample_ready` is high while `clear_start` is low.
- R2: Each accepted sample adds exactly one to the counter addressed by its key, for random mixes of keys with idle gaps.
- R3: Back-to-back samples with the same key, in runs of any length, raise that key's counter by the run length.
- R4: Samples that alternate every cycle between two keys give exact counts for both keys.
- R5: A sample offered with `sample_valid` low, or with `frame_valid` low, changes no counter.
- R6: A counter holding all-ones (2^CNT_W-1) stays at all-ones when more samples of its key arrive, and an update never writes zero.
- R7: When `clear_start` is sampled high with no sweep running, `sample_ready` is low for exactly 2^KEY_W cycles. Every counter then reads zero. `clear_done` is high for exactly one cycle, which is the first cycle in which `sample_ready` is high again.
- R8: Samples still in the pipeline when a clear starts are discarded, and no update write occurs during the sweep.
- R9: With no sample accepted on a rising edge, `rd_count` shows the counter at the `rd_addr` sampled on that edge, from the cycle after it onward. Reads must wait 4 cycles after the last accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Frame qualifier for the sample stream |
| sample_valid | input | 1 | Sample stream valid |
| sample_key | input | KEY_W | Sample key, also the counter address |
| sample_ready | output | 1 | Sample stream ready, low during a clear |
| clear_start | input | 1 | Pulse to start a clear sweep of all counters |
| clear_done | output | 1 | One-cycle pulse when the sweep has finished |
| rd_addr | input | KEY_W | Counter address for the downstream reader |
| rd_count | output | CNT_W | Counter read data, one cycle after the address |

## Verification
A sample taken on edge t reaches the RAM on edge t+3. A read address sampled on a later edge shows on `rd_count` one cycle after that edge. For these reasons the bench drops the frame, lets at least four idle edges pass, and then reads each key at the falling edge after its address was sampled. For a clear started on edge e0, the bench counts falling edges with `sample_ready` low and expects 2^KEY_W of them. It expects `clear_done` at the first falling edge with `sample_ready` high again and expects it to be gone one cycle later. Expected counts come from a bench array that is incremented per accepted sample and capped at the saturation value.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic {
    CLR_IDLE  = 1'b0,
    CLR_SWEEP = 1'b1
  } clr_state_e;
endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int KEY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic [KEY_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data
);
  localparam int DEPTH = 1 << KEY_W;

  logic [CNT_W-1:0] mem [DEPTH];

  // read returns the word as it was before a write on the same edge
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/hist_clear_seq.sv
module hist_clear_seq
  import hist_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [KEY_W-1:0] addr,
  output logic             done
);
  localparam logic [KEY_W-1:0] LAST = {KEY_W{1'b1}};

  clr_state_e state;

  assign busy = (state == CLR_SWEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CLR_IDLE;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        CLR_IDLE: begin
          if (start) begin
            state <= CLR_SWEEP;
            addr  <= '0;
          end
        end
        CLR_SWEEP: begin
          if (addr == LAST) begin
            state <= CLR_IDLE;
            done  <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        default: state <= CLR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hist_pipe.sv
module hist_pipe #(
  parameter int KEY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic [CNT_W-1:0] ram_q,
  output logic             wr_en,
  output logic [KEY_W-1:0] wr_addr,
  output logic [CNT_W-1:0] wr_data
);
  localparam int NFWD = 3; // stages younger than the RAM snapshot
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // stage 1: RAM data returns; stage 2: updated count; stage 3: write port
  logic             s1_v;
  logic [KEY_W-1:0] s1_k;
  logic             s2_v, s3_v, wl_v;
  logic [KEY_W-1:0] s2_k, s3_k, wl_k;
  logic [CNT_W-1:0] s2_c, s3_c, wl_c;

  // forwarding sources, youngest first
  logic [NFWD-1:0]  fv;
  logic [KEY_W-1:0] fk [NFWD];
  logic [CNT_W-1:0] fc [NFWD];

  assign fv    = {wl_v, s3_v, s2_v};
  assign fk[0] = s2_k;  assign fc[0] = s2_c;
  assign fk[1] = s3_k;  assign fc[1] = s3_c;
  assign fk[2] = wl_k;  assign fc[2] = wl_c;

  logic [NFWD-1:0] hit;
  for (genvar g = 0; g < NFWD; g++) begin : g_cmp
    assign hit[g] = fv[g] && (fk[g] == s1_k);
  end

  logic [CNT_W-1:0] base, upd;
  always_comb begin
    base = ram_q;
    for (int i = NFWD - 1; i >= 0; i--) begin
      if (hit[i]) base = fc[i];
    end
    upd = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      wl_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
      wl_v <= s3_v;
    end
    s1_k <= in_key;
    s2_k <= s1_k;
    s2_c <= upd;
    s3_k <= s2_k;
    s3_c <= s2_c;
    wl_k <= s3_k;
    wl_c <= s3_c;
  end

  assign wr_en   = s3_v;
  assign wr_addr = s3_k;
  assign wr_data = s3_c;
endmodule

// File: rtl/hist_count_updater.sv
module hist_count_updater #(
  parameter int KEY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             sample_valid,
  input  logic [KEY_W-1:0] sample_key,
  output logic             sample_ready,
  input  logic             clear_start,
  output logic             clear_done,
  input  logic [KEY_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_count
);
  logic             clr_busy;
  logic [KEY_W-1:0] clr_addr;
  logic             take;
  logic [KEY_W-1:0] ram_raddr;
  logic [CNT_W-1:0] ram_q;
  logic             pipe_wr_en;
  logic [KEY_W-1:0] pipe_wr_addr;
  logic [CNT_W-1:0] pipe_wr_data;
  logic             ram_wr_en;
  logic [KEY_W-1:0] ram_wr_addr;
  logic [CNT_W-1:0] ram_wr_data;

  assign sample_ready = !clr_busy && !clear_start;
  assign take         = frame_valid && sample_valid && sample_ready;
  assign ram_raddr    = take ? sample_key : rd_addr;
  assign rd_count     = ram_q;

  hist_clear_seq #(.KEY_W(KEY_W)) u_clear (
    .clk   (clk),
    .rst_n (rst_n),
    .start (clear_start),
    .busy  (clr_busy),
    .addr  (clr_addr),
    .done  (clear_done)
  );

  hist_pipe #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (clear_start && !clr_busy),
    .in_valid(take),
    .in_key  (sample_key),
    .ram_q   (ram_q),
    .wr_en   (pipe_wr_en),
    .wr_addr (pipe_wr_addr),
    .wr_data (pipe_wr_data)
  );

  assign ram_wr_en   = clr_busy || pipe_wr_en;
  assign ram_wr_addr = clr_busy ? clr_addr : pipe_wr_addr;
  assign ram_wr_data = clr_busy ? '0 : pipe_wr_data;

  hist_ram #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_ram (
    .clk     (clk),
    .rd_addr (ram_raddr),
    .rd_data (ram_q),
    .wr_en   (ram_wr_en),
    .wr_addr (ram_wr_addr),
    .wr_data (ram_wr_data)
  );
endmodule

// File: rtl/hist_count_updater_sva.sv
module hist_count_updater_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_start,
  input logic             sample_ready,
  input logic             clear_done,
  input logic             clr_busy,
  input logic             pipe_wr_en,
  input logic [CNT_W-1:0] pipe_wr_data
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !clear_done && !clr_busy);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_wr_en |-> pipe_wr_data != '0);

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_start && !clr_busy |=> !sample_ready);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_done |=> !clear_done);

  assert_done_after_sweep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_done |-> $past(clr_busy) && !clr_busy);

  assert_no_update_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !pipe_wr_en);
endmodule

bind hist_count_updater hist_count_updater_sva #(.CNT_W(CNT_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear_start  (clear_start),
  .sample_ready (sample_ready),
  .clear_done   (clear_done),
  .clr_busy     (clr_busy),
  .pipe_wr_en   (pipe_wr_en),
  .pipe_wr_data (pipe_wr_data)
);

// File: tb/hist_count_updater_bench.sv
`timescale 1ns/1ps
module hist_count_updater_bench;
  localparam int KW = 4;
  localparam int CW = 6;
  localparam int NK = 1 << KW;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_valid = 1'b0;
  logic          sample_valid = 1'b0;
  logic [KW-1:0] sample_key = '0;
  logic          sample_ready;
  logic          clear_start = 1'b0;
  logic          clear_done;
  logic [KW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_count;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int model [NK];

  always #2 clk = ~clk;

  hist_count_updater #(.KEY_W(KW), .CNT_W(CW)) u_hist_count_updater (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .sample_valid(sample_valid), .sample_key(sample_key),
    .sample_ready(sample_ready), .clear_start(clear_start),
    .clear_done(clear_done), .rd_addr(rd_addr), .rd_count(rd_count)
  );

  function automatic int expect_cnt(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input bit fv, input bit sv, input int k);
    @(negedge clk);
    frame_valid  = fv;
    sample_valid = sv;
    sample_key   = KW'(k);
    if (fv && sv && sample_ready) model[k]++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_valid  = 1'b0;
      sample_valid = 1'b0;
    end
  endtask

  // R9 read port used to bring every counter out
  task automatic check_all(input string req);
    idle(5);
    for (int k = 0; k < NK; k++) begin
      rd_addr = KW'(k);
      @(negedge clk);
      check(req, int'(rd_count), expect_cnt(model[k]));
    end
  endtask

  task automatic do_clear(input string req);
    int cnt;
    @(negedge clk);
    frame_valid  = 1'b0;
    sample_valid = 1'b0;
    clear_start  = 1'b1;
    @(negedge clk);
    clear_start = 1'b0;
    cnt = 0;
    while (!sample_ready && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check({req, " ready-low cycles"}, cnt, NK);
    check({req, " done pulse"}, int'(clear_done), 1);
    @(negedge clk);
    check({req, " done single"}, int'(clear_done), 0);
    for (int k = 0; k < NK; k++) model[k] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd4711));
    for (int k = 0; k < NK; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(sample_ready), 1);
    check("R1 done", int'(clear_done), 0);

    do_clear("R7 first");
    check_all("R7 zero after clear");

    // R3 long run of one key
    for (int i = 0; i < 25; i++) put(1, 1, 6);
    check_all("R3 run");

    // R4 fast toggling
    for (int i = 0; i < 30; i++) put(1, 1, (i % 2) ? 3 : 12);
    put(1, 1, 3); put(1, 1, 3); put(1, 1, 12);
    check_all("R4 toggle");

    // R5 ignored samples
    put(1, 0, 9); put(0, 1, 9); put(1, 0, 2); put(0, 1, 2);
    check_all("R5 ignored");

    // R2 constrained random: runs, repeats at distance 2..3, gaps
    prev = 0;
    for (int i = 0; i < 400; i++) begin
      int r, k;
      r = $urandom_range(0, 99);
      if (r < 40) k = prev;
      else if (r < 60) k = $urandom_range(0, 2);
      else k = $urandom_range(0, NK - 1);
      put(1, ($urandom_range(0, 9) != 0), k);
      prev = k;
    end
    check_all("R2 random");

    // R6 saturation
    do_clear("R7 second");
    for (int i = 0; i < CMAX + 8; i++) put(1, 1, 5);
    put(1, 1, 4); put(1, 1, 5); put(1, 1, 4);
    check_all("R6 saturate");

    // R8 clear with samples in flight
    for (int i = 0; i < 6; i++) put(1, 1, 2);
    do_clear("R8 flush");
    check_all("R8 counters zero");

    // counting resumes after a clear
    for (int i = 0; i < 7; i++) put(1, 1, 15);
    put(1, 1, 0);
    check_all("R2 after clear");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule